// File: doc/BRIEF.md
# Register Rename Unit with Committed Map

This block renames architectural registers onto a larger pool of physical registers for a single-issue core that executes out of order. It holds two maps. One is a speculative map that each rename updates. The other is a committed map that changes only when the oldest instruction retires. It also keeps a bit-vector free list of physical registers, a ready bit for each physical register, and a circular in-order buffer of in-flight renames. Each buffer entry records the destination register, its new tag and the tag it replaced.

On each cycle the rename port looks up both source registers in the speculative map and returns their tags and ready bits. When the rename fires, the block takes a free physical register for the destination. A writeback port marks a tag as holding its value. A commit port retires the oldest entry once that entry's new tag is ready: it moves the destination in the committed map to the new tag and returns the replaced tag to the free list. A flush recovers from a misprediction. It copies the whole committed map over the speculative map, empties the buffer and rebuilds the free list from the tags that the committed map does not use.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register n maps to physical register n in both maps. Physical registers 0 to 7 are ready and not free. Physical registers 8 to 15 are free and not ready.
- R2: The source tags and source ready bits are read combinationally from the speculative map and the ready table as they stood at the start of the cycle. A writeback in the same cycle is not forwarded.
- R3: A rename that fires takes the lowest-numbered free physical register as `ren_new_tag` and writes it into the speculative map at the clock edge. A source equal to the instruction's own destination still returns the previous mapping.
- R4: A newly allocated tag reads not ready. A writeback of a tag makes it read ready from the following cycle.
- R5: `ren_ready` is low when the free list is empty, when the buffer holds ROB_DEPTH entries, or when `flush` is high. A rename request made while `ren_ready` is low changes no state.
- R6: Each fired rename is recorded in program order. The commit outputs report the oldest entry's destination register, new tag and replaced tag.
- R7: `cmt_fire` is high only when `cmt_req` is high, `flush` is low, the buffer is not empty and the oldest entry's new tag is ready. Entries retire strictly oldest first.
- R8: A commit updates the committed map entry to the new tag. The replaced tag becomes free and can be allocated from the next cycle.
- R9: A flush makes the speculative map equal to the committed map and empties the buffer. It leaves free exactly the physical registers that the committed map does not name, and marks every named one ready. No rename or commit fires in the flush cycle.
- R10: At every cycle outside reset, the number of free physical registers plus the buffer occupancy equals the number of physical registers minus the number of architectural registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request |
| ren_src_a | input | 3 | First source architectural register |
| ren_src_b | input | 3 | Second source architectural register |
| ren_dst | input | 3 | Destination architectural register |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| ren_tag_a | output | 4 | Physical tag of first source |
| ren_rdy_a | output | 1 | First source value available |
| ren_tag_b | output | 4 | Physical tag of second source |
| ren_rdy_b | output | 1 | Second source value available |
| ren_new_tag | output | 4 | Physical tag allocated for the destination |
| wb_valid | input | 1 | Writeback of a result |
| wb_tag | input | 4 | Tag whose value is now available |
| cmt_req | input | 1 | Request to retire the oldest entry |
| cmt_fire | output | 1 | Oldest entry retires this cycle |
| cmt_arch | output | 3 | Destination register of the oldest entry |
| cmt_new_tag | output | 4 | New tag of the oldest entry |
| cmt_old_tag | output | 4 | Replaced tag of the oldest entry |
| flush | input | 1 | Misprediction recovery |

## Verification
The bench fills the buffer until the free list runs dry and then checks that the next rename is refused. A design that miscounted occupancy would hand out a tag that is still in use. It writes back a younger result before an older one to confirm that commit waits for the oldest entry; a design that retired out of order would free a tag that a later instruction still reads. It renames an instruction whose source equals its destination, and it sends a writeback in the same cycle as a lookup, which exposes a design that forwards or updates too early. It flushes with squashed tags outstanding and then checks the restored mappings and which tags are allocated next. A free list rebuilt wrongly would either lose the squashed tags or hand out a committed one.

// File: rtl/rn_pkg.sv
package rn_pkg;
   // Order in which the free list hands out physical registers.
   typedef enum logic {
      PICK_LOW  = 1'b0,
      PICK_HIGH = 1'b1
   } pick_e;
endpackage

// File: rtl/rn_map.sv
module rn_map #(
   parameter int NUM_ARCH = 8,
   parameter int NUM_PHYS = 16,
   localparam int AW = $clog2(NUM_ARCH),
   localparam int PW = $clog2(NUM_PHYS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [AW-1:0]          rd_a,
   input  logic [AW-1:0]          rd_b,
   input  logic [AW-1:0]          rd_d,
   output logic [PW-1:0]          tag_a,
   output logic [PW-1:0]          tag_b,
   output logic [PW-1:0]          tag_d,
   input  logic                   wr_en,
   input  logic [AW-1:0]          wr_arch,
   input  logic [PW-1:0]          wr_tag,
   input  logic                   cm_en,
   input  logic [AW-1:0]          cm_arch,
   input  logic [PW-1:0]          cm_tag,
   input  logic                   restore,
   output logic [NUM_ARCH*PW-1:0] spec_flat,
   output logic [NUM_ARCH*PW-1:0] cmt_flat,
   output logic [NUM_PHYS-1:0]    cmt_refs
);
   logic [PW-1:0] spec_q [NUM_ARCH];
   logic [PW-1:0] cmt_q  [NUM_ARCH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_ARCH; i++) begin
            spec_q[i] <= PW'(i);
            cmt_q[i]  <= PW'(i);
         end
      end else begin
         if (restore) begin
            for (int i = 0; i < NUM_ARCH; i++) spec_q[i] <= cmt_q[i];
         end else if (wr_en) begin
            spec_q[wr_arch] <= wr_tag;
         end
         if (cm_en) cmt_q[cm_arch] <= cm_tag;
      end
   end

   assign tag_a = spec_q[rd_a];
   assign tag_b = spec_q[rd_b];
   assign tag_d = spec_q[rd_d];

   // Physical registers referenced by the committed map.
   always_comb begin
      cmt_refs = '0;
      for (int i = 0; i < NUM_ARCH; i++) cmt_refs[cmt_q[i]] = 1'b1;
   end

   for (genvar g = 0; g < NUM_ARCH; g++) begin : g_flat
      assign spec_flat[g*PW +: PW] = spec_q[g];
      assign cmt_flat[g*PW +: PW]  = cmt_q[g];
   end
endmodule

// File: rtl/rn_freelist.sv
module rn_freelist
   import rn_pkg::*;
#(
   parameter int    NUM_ARCH = 8,
   parameter int    NUM_PHYS = 16,
   parameter pick_e PICK     = PICK_LOW,
   localparam int   PW = $clog2(NUM_PHYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                alloc_en,
   input  logic                rel_en,
   input  logic [PW-1:0]       rel_tag,
   input  logic                rebuild,
   input  logic [NUM_PHYS-1:0] keep,
   output logic [NUM_PHYS-1:0] free_vec,
   output logic                any_free,
   output logic [PW-1:0]       pick_tag
);
   logic [NUM_PHYS-1:0] free_q, free_d;

   if (PICK == PICK_LOW) begin : g_pick_low
      always_comb begin
         pick_tag = '0;
         for (int i = NUM_PHYS - 1; i >= 0; i--)
            if (free_q[i]) pick_tag = PW'(i);
      end
   end else begin : g_pick_high
      always_comb begin
         pick_tag = '0;
         for (int i = 0; i < NUM_PHYS; i++)
            if (free_q[i]) pick_tag = PW'(i);
      end
   end

   assign any_free = |free_q;
   assign free_vec = free_q;

   always_comb begin
      free_d = free_q;
      if (rebuild) begin
         free_d = ~keep;
      end else begin
         if (alloc_en) free_d[pick_tag] = 1'b0;
         if (rel_en)   free_d[rel_tag]  = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_PHYS; i++) free_q[i] <= (i >= NUM_ARCH);
      end else begin
         free_q <= free_d;
      end
   end
endmodule

// File: rtl/rn_readytab.sv
module rn_readytab #(
   parameter int NUM_ARCH = 8,
   parameter int NUM_PHYS = 16,
   localparam int PW = $clog2(NUM_PHYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_en,
   input  logic [PW-1:0]       set_tag,
   input  logic                clr_en,
   input  logic [PW-1:0]       clr_tag,
   input  logic                restore,
   input  logic [NUM_PHYS-1:0] keep,
   output logic [NUM_PHYS-1:0] ready_vec
);
   logic [NUM_PHYS-1:0] rdy_q, rdy_d;

   always_comb begin
      rdy_d = rdy_q;
      if (set_en)  rdy_d[set_tag] = 1'b1;
      if (clr_en)  rdy_d[clr_tag] = 1'b0;
      if (restore) rdy_d = rdy_d | keep;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_PHYS; i++) rdy_q[i] <= (i < NUM_ARCH);
      end else begin
         rdy_q <= rdy_d;
      end
   end

   assign ready_vec = rdy_q;
endmodule

// File: rtl/rn_rob.sv
module rn_rob #(
   parameter int DEPTH = 8,
   parameter int AW    = 3,
   parameter int PW    = 4,
   localparam int RW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_arch,
   input  logic [PW-1:0] push_new,
   input  logic [PW-1:0] push_old,
   input  logic          pop,
   input  logic          clear,
   output logic [AW-1:0] head_arch,
   output logic [PW-1:0] head_new,
   output logic [PW-1:0] head_old,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] count
);
   logic [AW-1:0] ent_arch [DEPTH];
   logic [PW-1:0] ent_new  [DEPTH];
   logic [PW-1:0] ent_old  [DEPTH];
   logic [RW-1:0] head_q, tail_q;
   logic [CW-1:0] cnt_q;

   function automatic logic [RW-1:0] step_ptr(input logic [RW-1:0] p);
      return (p == RW'(DEPTH - 1)) ? '0 : p + RW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (push) begin
         ent_arch[tail_q] <= push_arch;
         ent_new[tail_q]  <= push_new;
         ent_old[tail_q]  <= push_old;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else if (clear) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) tail_q <= step_ptr(tail_q);
         if (pop)  head_q <= step_ptr(head_q);
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign head_arch = ent_arch[head_q];
   assign head_new  = ent_new[head_q];
   assign head_old  = ent_old[head_q];
   assign empty     = (cnt_q == '0);
   assign full      = (cnt_q == CW'(DEPTH));
   assign count     = cnt_q;
endmodule

// File: rtl/rename_unit.sv
module rename_unit
   import rn_pkg::*;
#(
   parameter int    NUM_ARCH  = 8,
   parameter int    NUM_PHYS  = 16,
   parameter int    ROB_DEPTH = 8,
   parameter pick_e PICK      = PICK_LOW,
   localparam int   AW = $clog2(NUM_ARCH),
   localparam int   PW = $clog2(NUM_PHYS),
   localparam int   CW = $clog2(ROB_DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ren_valid,
   input  logic [AW-1:0] ren_src_a,
   input  logic [AW-1:0] ren_src_b,
   input  logic [AW-1:0] ren_dst,
   output logic          ren_ready,
   output logic [PW-1:0] ren_tag_a,
   output logic          ren_rdy_a,
   output logic [PW-1:0] ren_tag_b,
   output logic          ren_rdy_b,
   output logic [PW-1:0] ren_new_tag,
   input  logic          wb_valid,
   input  logic [PW-1:0] wb_tag,
   input  logic          cmt_req,
   output logic          cmt_fire,
   output logic [AW-1:0] cmt_arch,
   output logic [PW-1:0] cmt_new_tag,
   output logic [PW-1:0] cmt_old_tag,
   input  logic          flush
);
   if (NUM_PHYS <= NUM_ARCH) begin : g_chk_pool
      $error("rename_unit: NUM_PHYS must exceed NUM_ARCH");
   end
   if (NUM_ARCH < 2 || (1 << AW) != NUM_ARCH) begin : g_chk_arch
      $error("rename_unit: NUM_ARCH must be a power of two, at least 2");
   end
   if ((1 << PW) != NUM_PHYS) begin : g_chk_phys
      $error("rename_unit: NUM_PHYS must be a power of two");
   end
   if (ROB_DEPTH < 2) begin : g_chk_rob
      $error("rename_unit: ROB_DEPTH must be at least 2");
   end

   logic [NUM_ARCH*PW-1:0] spec_flat, cmt_flat;
   logic [NUM_PHYS-1:0]    cmt_refs, free_vec, ready_vec;
   logic                   any_free, rob_empty, rob_full, ren_fire;
   logic [PW-1:0]          old_tag;
   logic [CW-1:0]          rob_count;

   assign ren_ready = !flush && any_free && !rob_full;
   assign ren_fire  = ren_valid && ren_ready;
   assign cmt_fire  = cmt_req && !flush && !rob_empty && ready_vec[cmt_new_tag];

   rn_map #(
      .NUM_ARCH (NUM_ARCH),
      .NUM_PHYS (NUM_PHYS)
   ) u_map (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_a      (ren_src_a),
      .rd_b      (ren_src_b),
      .rd_d      (ren_dst),
      .tag_a     (ren_tag_a),
      .tag_b     (ren_tag_b),
      .tag_d     (old_tag),
      .wr_en     (ren_fire),
      .wr_arch   (ren_dst),
      .wr_tag    (ren_new_tag),
      .cm_en     (cmt_fire),
      .cm_arch   (cmt_arch),
      .cm_tag    (cmt_new_tag),
      .restore   (flush),
      .spec_flat (spec_flat),
      .cmt_flat  (cmt_flat),
      .cmt_refs  (cmt_refs)
   );

   rn_freelist #(
      .NUM_ARCH (NUM_ARCH),
      .NUM_PHYS (NUM_PHYS),
      .PICK     (PICK)
   ) u_free (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc_en (ren_fire),
      .rel_en   (cmt_fire),
      .rel_tag  (cmt_old_tag),
      .rebuild  (flush),
      .keep     (cmt_refs),
      .free_vec (free_vec),
      .any_free (any_free),
      .pick_tag (ren_new_tag)
   );

   rn_readytab #(
      .NUM_ARCH (NUM_ARCH),
      .NUM_PHYS (NUM_PHYS)
   ) u_rdy (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (wb_valid),
      .set_tag   (wb_tag),
      .clr_en    (ren_fire),
      .clr_tag   (ren_new_tag),
      .restore   (flush),
      .keep      (cmt_refs),
      .ready_vec (ready_vec)
   );

   assign ren_rdy_a = ready_vec[ren_tag_a];
   assign ren_rdy_b = ready_vec[ren_tag_b];

   rn_rob #(
      .DEPTH (ROB_DEPTH),
      .AW    (AW),
      .PW    (PW)
   ) u_rob (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (ren_fire),
      .push_arch (ren_dst),
      .push_new  (ren_new_tag),
      .push_old  (old_tag),
      .pop       (cmt_fire),
      .clear     (flush),
      .head_arch (cmt_arch),
      .head_new  (cmt_new_tag),
      .head_old  (cmt_old_tag),
      .empty     (rob_empty),
      .full      (rob_full),
      .count     (rob_count)
   );
endmodule

// File: rtl/rn_checker.sv
module rn_checker #(
   parameter int NUM_ARCH  = 8,
   parameter int NUM_PHYS  = 16,
   parameter int ROB_DEPTH = 8,
   localparam int AW = $clog2(NUM_ARCH),
   localparam int PW = $clog2(NUM_PHYS),
   localparam int CW = $clog2(ROB_DEPTH + 1)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   flush,
   input logic                   ren_ready,
   input logic                   ren_fire,
   input logic [AW-1:0]          ren_dst,
   input logic [PW-1:0]          ren_new_tag,
   input logic                   cmt_fire,
   input logic [PW-1:0]          cmt_old_tag,
   input logic [NUM_ARCH*PW-1:0] spec_flat,
   input logic [NUM_ARCH*PW-1:0] cmt_flat,
   input logic [NUM_PHYS-1:0]    free_vec,
   input logic [CW-1:0]          rob_count
);
   logic [PW-1:0] spec_arr [NUM_ARCH];
   for (genvar g = 0; g < NUM_ARCH; g++) begin : g_unflat
      assign spec_arr[g] = spec_flat[g*PW +: PW];
   end

   // R10: free registers plus in-flight entries stay constant
   assert_pool_balance_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (int'($countones(free_vec)) + int'(rob_count)) == (NUM_PHYS - NUM_ARCH));

   // R3: a fired rename lands in the speculative map
   assert_map_written_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ren_fire |=> (spec_arr[$past(ren_dst)] == $past(ren_new_tag)));

   // R5: a full buffer refuses renames
   assert_full_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rob_count == CW'(ROB_DEPTH)) |-> !ren_ready);

   // R9: after a flush both maps agree and the buffer is empty
   assert_flush_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (spec_flat == cmt_flat) && (rob_count == '0));

   // R8: a retired replaced tag is free on the next cycle
   assert_old_tag_freed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_fire |=> free_vec[$past(cmt_old_tag)]);
endmodule

bind rename_unit rn_checker #(
   .NUM_ARCH  (NUM_ARCH),
   .NUM_PHYS  (NUM_PHYS),
   .ROB_DEPTH (ROB_DEPTH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush       (flush),
   .ren_ready   (ren_ready),
   .ren_fire    (ren_fire),
   .ren_dst     (ren_dst),
   .ren_new_tag (ren_new_tag),
   .cmt_fire    (cmt_fire),
   .cmt_old_tag (cmt_old_tag),
   .spec_flat   (spec_flat),
   .cmt_flat    (cmt_flat),
   .free_vec    (free_vec),
   .rob_count   (rob_count)
);

// File: tb/rename_unit_tb.sv
`timescale 1ns/1ps
module rename_unit_tb;
   localparam int NA = 8;
   localparam int NP = 16;
   localparam int RD = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ren_valid = 1'b0;
   logic [2:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
   logic       ren_ready, ren_rdy_a, ren_rdy_b;
   logic [3:0] ren_tag_a, ren_tag_b, ren_new_tag;
   logic       wb_valid = 1'b0;
   logic [3:0] wb_tag = '0;
   logic       cmt_req = 1'b0;
   logic       cmt_fire;
   logic [2:0] cmt_arch;
   logic [3:0] cmt_new_tag, cmt_old_tag;
   logic       flush = 1'b0;

   always #2.5 clk = ~clk;

   rename_unit u_dut (
      .clk(clk), .rst_n(rst_n),
      .ren_valid(ren_valid), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
      .ren_dst(ren_dst), .ren_ready(ren_ready),
      .ren_tag_a(ren_tag_a), .ren_rdy_a(ren_rdy_a),
      .ren_tag_b(ren_tag_b), .ren_rdy_b(ren_rdy_b),
      .ren_new_tag(ren_new_tag),
      .wb_valid(wb_valid), .wb_tag(wb_tag),
      .cmt_req(cmt_req), .cmt_fire(cmt_fire), .cmt_arch(cmt_arch),
      .cmt_new_tag(cmt_new_tag), .cmt_old_tag(cmt_old_tag),
      .flush(flush)
   );

   typedef struct {
      logic       rr;
      logic [3:0] ta, tb, tn;
      logic       ra, rb;
      logic       cf;
      logic [2:0] ca;
      logic [3:0] cn, co;
   } exp_t;

   typedef struct {
      logic [2:0] arch;
      logic [3:0] nt, ot;
   } rob_t;

   exp_t  exp_q[$];
   string req_q[$];
   int    n_vec = 0;
   int    n_bad = 0;

   // reference model state
   logic [3:0] m_spec [NA];
   logic [3:0] m_cmt  [NA];
   logic       m_free [NP];
   logic       m_rdy  [NP];
   rob_t       m_rob[$];

   function automatic int low_free();
      for (int i = 0; i < NP; i++) if (m_free[i]) return i;
      return -1;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NA; i++) begin m_spec[i] = 4'(i); m_cmt[i] = 4'(i); end
      for (int i = 0; i < NP; i++) begin m_free[i] = (i >= NA); m_rdy[i] = (i < NA); end
      m_rob.delete();
   endtask

   // driver: apply one cycle of stimulus and queue what must appear
   task automatic step(input logic rv, input int a, input int b, input int d,
                       input logic wv, input int wt, input logic cr,
                       input logic fl, input string req);
      exp_t e;
      rob_t r;
      int   nf;
      @(posedge clk); #1;
      ren_valid = rv; ren_src_a = 3'(a); ren_src_b = 3'(b); ren_dst = 3'(d);
      wb_valid = wv; wb_tag = 4'(wt); cmt_req = cr; flush = fl;
      nf   = low_free();
      e.rr = !fl && (nf >= 0) && (m_rob.size() < RD);
      e.ta = m_spec[a]; e.tb = m_spec[b];
      e.ra = m_rdy[m_spec[a]]; e.rb = m_rdy[m_spec[b]];
      e.tn = (nf >= 0) ? 4'(nf) : 4'd0;
      e.cf = cr && !fl && (m_rob.size() > 0) && m_rdy[m_rob[0].nt];
      e.ca = (m_rob.size() > 0) ? m_rob[0].arch : 3'd0;
      e.cn = (m_rob.size() > 0) ? m_rob[0].nt : 4'd0;
      e.co = (m_rob.size() > 0) ? m_rob[0].ot : 4'd0;
      exp_q.push_back(e);
      req_q.push_back(req);
      // state after the edge
      if (wv) m_rdy[wt] = 1'b1;
      if (fl) begin
         for (int i = 0; i < NA; i++) m_spec[i] = m_cmt[i];
         for (int i = 0; i < NP; i++) m_free[i] = 1'b1;
         for (int i = 0; i < NA; i++) begin m_free[m_cmt[i]] = 1'b0; m_rdy[m_cmt[i]] = 1'b1; end
         m_rob.delete();
      end else begin
         if (e.cf) begin
            r = m_rob.pop_front();
            m_cmt[r.arch] = r.nt;
            m_free[r.ot]  = 1'b1;
         end
         if (rv && e.rr) begin
            r.arch = 3'(d); r.nt = e.tn; r.ot = m_spec[d];
            m_rob.push_back(r);
            m_spec[d]     = e.tn;
            m_free[e.tn]  = 1'b0;
            m_rdy[e.tn]   = 1'b0;
         end
      end
   endtask

   task automatic cmp(input string req, input string what, input int act, input int exp_v,
                      inout bit bad);
      if (act != exp_v) begin
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp_v, $time);
         bad = 1'b1;
      end
   endtask

   // monitor: compare the design's outputs mid-cycle
   always @(negedge clk) begin : monitor
      exp_t  e;
      string rq;
      bit    bad;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         rq = req_q.pop_front();
         bad = 1'b0;
         cmp(rq, "ren_ready", int'(ren_ready), int'(e.rr), bad);
         cmp(rq, "ren_tag_a", int'(ren_tag_a), int'(e.ta), bad);
         cmp(rq, "ren_tag_b", int'(ren_tag_b), int'(e.tb), bad);
         cmp(rq, "ren_rdy_a", int'(ren_rdy_a), int'(e.ra), bad);
         cmp(rq, "ren_rdy_b", int'(ren_rdy_b), int'(e.rb), bad);
         if (e.rr) cmp(rq, "ren_new_tag", int'(ren_new_tag), int'(e.tn), bad);
         cmp(rq, "cmt_fire", int'(cmt_fire), int'(e.cf), bad);
         if (e.cf) begin
            cmp(rq, "cmt_arch", int'(cmt_arch), int'(e.ca), bad);
            cmp(rq, "cmt_new_tag", int'(cmt_new_tag), int'(e.cn), bad);
            cmp(rq, "cmt_old_tag", int'(cmt_old_tag), int'(e.co), bad);
         end
         n_vec++;
         if (bad) n_bad++;
      end
   end

   bit finished = 1'b0;

   initial begin : watchdog
      #(200000 * 5);
      if (!finished) begin
         $display("FAIL watchdog expired actual=running expected=done");
         n_bad++;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : stimulus
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: identity mapping, P0..P7 ready, first free tag is P8
      step(0, 3, 5, 0, 0, 0, 0, 0, "R1");
      // R3: lowest free tag taken
      step(1, 0, 0, 1, 0, 0, 0, 0, "R3");
      // R4: the fresh tag reads not ready; R2: lookup from speculative map
      step(1, 1, 1, 2, 0, 0, 0, 0, "R4");
      // R3: source equal to destination sees previous mapping
      step(1, 1, 2, 1, 0, 0, 0, 0, "R3");
      for (int k = 3; k < 8; k++) step(1, k, 0, k, 0, 0, 0, 0, "R3");
      // R5, R10: free list exhausted and buffer full, the request is refused
      step(1, 0, 1, 0, 0, 0, 0, 0, "R5");
      // R7: oldest entry incomplete, no retirement
      step(0, 1, 2, 0, 0, 0, 1, 0, "R7");
      // R7: younger entry written back first, still blocked; R2: no same-cycle forwarding
      step(0, 2, 1, 0, 1, 9, 1, 0, "R7");
      // R4: writeback of the oldest tag is seen only next cycle
      step(0, 2, 1, 0, 1, 8, 1, 0, "R4");
      // R6: oldest entry retires with its recorded fields; free list still empty
      step(1, 1, 2, 0, 0, 0, 1, 0, "R6");
      // R8: tag freed last cycle is allocated now, second entry retires
      step(1, 1, 2, 0, 0, 0, 1, 0, "R8");
      // R7: third entry not complete
      step(0, 1, 2, 0, 0, 0, 1, 0, "R7");
      // R9: nothing fires in the flush cycle
      step(1, 1, 2, 4, 0, 0, 1, 1, "R9");
      // R9: restored mapping, rebuilt free list
      step(1, 1, 2, 5, 0, 0, 0, 0, "R9");
      step(1, 5, 0, 6, 0, 0, 0, 0, "R9");
      step(0, 6, 5, 0, 0, 0, 1, 0, "R9");

      // mixed traffic against the model
      for (int n = 0; n < 600; n++) begin
         step(($urandom % 4) != 0, $urandom % NA, $urandom % NA, $urandom % NA,
              ($urandom % 2) == 1, $urandom % NP, ($urandom % 3) != 0,
              ($urandom % 40) == 0, "R2/R7 mixed");
      end
      step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
      @(posedge clk); #1;
      ren_valid = 1'b0; wb_valid = 1'b0; cmt_req = 1'b0; flush = 1'b0;
      repeat (3) @(posedge clk);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule